// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous memory whose words are split into byte lanes. Each lane holds eight data bits and a parity bit, and the lane moves as one unit. The rising clock edge captures the address, the write data and all control inputs. A write finishes in the cycle after it is captured and needs no further timing from outside the block.

A selected cycle either writes or reads. It writes when the global write input is low, or when the byte-write enable is low and at least one lane strobe is low. In every other selected cycle it reads. Read data passes through an output register and is shown one cycle after the address is captured. A read that directly follows a write sees the new bytes. Bypass logic merges the lanes that were just written over the stale word from the memory. The block is made to sit behind an external burst address generator.

The chip-select acts through the pipeline, so the output drive switches off two cycles after a deselect. The output enable gates the output at once, with no clock involved.

Top module: `bw_sync_sram`

## Requirements
- R1: While reset is high and in the cycle after it, `q_drv` is 0 and `q_o` is all zeros.
- R2: A read captured at clock edge k drives the stored word on `q_o`, with `q_drv` high, after edge k+1.
- R3: When `gw_n` is low in a selected cycle, all lanes are written, whatever the values of `bwe_n` and `bw_n`.
- R4: When `bwe_n` is high and `gw_n` is high, the lane strobes have no effect and the cycle is a read.
- R5: Bit n of `bw_n` (active low) selects lane n, which is bits [9n+8:9n] of the word with the parity bit at 9n+8. A strobed write changes only the lanes it selects.
- R6: A read captured in the cycle right after a write to the same address returns the written lanes merged with the old contents of the lanes that were not written.
- R7: A cycle captured with `ce_n` high drives `q_drv` low after the following edge, which is two edges after it was captured.
- R8: With `oe_n` high, `q_drv` is 0 and `q_o` is zero straight away, without waiting for a clock edge.
- R9: A cycle with `ce_n` high writes nothing, even if `gw_n` is low.
- R10: A selected cycle with `bwe_n` low, all strobes high and `gw_n` high is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low, pipelined |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies `bw_n` |
| bw_n | input | LANES | Per-lane write strobes, active low |
| addr_i | input | AW | Word address |
| d_i | input | 9*LANES | Write data, lane n at bits [9n+8:9n] |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| q_o | output | 9*LANES | Read data, zero when not driven |
| q_drv | output | 1 | High while `q_o` carries valid driven data |

## Verification
Assertions check on every cycle the things that a port-level property can describe. These are the reset idle state, the read-to-drive latency, and the two-edge turn-off after a deselect. They also check that the output enable blocks the output, that a global write sets all lane enables, and that strobes have no effect while byte-write is disabled or the chip is deselected. Data integrity needs the bench's reference memory. This covers the values of partial-lane writes, the merge of a write with the read right after it, the cases where a decode falls back to a read, and the immediate effect of the output enable in the middle of a cycle.

// File: rtl/bwsram_pkg.sv
package bwsram_pkg;
  localparam int unsigned LANE_BITS = 9;

  function automatic int unsigned word_bits(input int unsigned lanes);
    return lanes * LANE_BITS;
  endfunction
endpackage

// File: rtl/bwsram_wr_decode.sv
module bwsram_wr_decode #(
  parameter int unsigned LANES = 4
) (
  input  logic             ce_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  output logic [LANES-1:0] lane_we,
  output logic             wr_en,
  output logic             rd_en
);
  logic [LANES-1:0] strobes;

  always_comb begin
    strobes = bwe_n ? '0 : ~bw_n;
    lane_we = gw_n ? strobes : '1;
    wr_en   = !ce_n && (|lane_we);
    rd_en   = !ce_n && !(|lane_we);
  end
endmodule

// File: rtl/bwsram_store.sv
module bwsram_store
  import bwsram_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 8
) (
  input  logic                        clk,
  input  logic [LANES-1:0]            we_mask,
  input  logic [AW-1:0]               waddr,
  input  logic [LANES*LANE_BITS-1:0]  wdata,
  input  logic                        re,
  input  logic [AW-1:0]               raddr,
  output logic [LANES*LANE_BITS-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] cells [DEPTH];
    always_ff @(posedge clk) begin
      if (we_mask[g]) cells[waddr] <= wdata[g*LANE_BITS +: LANE_BITS];
      if (re) rdata[g*LANE_BITS +: LANE_BITS] <= cells[raddr];
    end
  end
endmodule

// File: rtl/bw_sync_sram.sv
module bw_sync_sram
  import bwsram_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ce_n,
  input  logic                        gw_n,
  input  logic                        bwe_n,
  input  logic [LANES-1:0]            bw_n,
  input  logic [AW-1:0]               addr_i,
  input  logic [LANES*LANE_BITS-1:0]  d_i,
  input  logic                        oe_n,
  output logic [LANES*LANE_BITS-1:0]  q_o,
  output logic                        q_drv
);
  localparam int unsigned W = LANES * LANE_BITS;

  logic [LANES-1:0] lane_we;
  logic             wr_now, rd_now;

  // stage A: captured write, read flag, bypass capture
  logic             wr_a, rd_a;
  logic [AW-1:0]    wa_a;
  logic [W-1:0]     wd_a;
  logic [LANES-1:0] wm_a;
  logic [LANES-1:0] byp_m;
  logic [W-1:0]     byp_d;
  logic [W-1:0]     raw_rd;
  logic [W-1:0]     merged;

  // stage B: output register
  logic [W-1:0]     q_reg;
  logic             q_en_r;

  bwsram_wr_decode #(.LANES(LANES)) u_dec (
    .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .lane_we(lane_we), .wr_en(wr_now), .rd_en(rd_now)
  );

  bwsram_store #(.LANES(LANES), .AW(AW)) u_store (
    .clk(clk),
    .we_mask(wr_a ? wm_a : '0),
    .waddr(wa_a),
    .wdata(wd_a),
    .re(rd_now),
    .raddr(addr_i),
    .rdata(raw_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_a  <= 1'b0;
      rd_a  <= 1'b0;
      wm_a  <= '0;
      byp_m <= '0;
    end else begin
      wr_a  <= wr_now;
      rd_a  <= rd_now;
      wm_a  <= lane_we;
      byp_m <= (rd_now && wr_a && (wa_a == addr_i)) ? wm_a : '0;
    end
    wa_a  <= addr_i;
    wd_a  <= d_i;
    byp_d <= wd_a;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[g*LANE_BITS +: LANE_BITS] = byp_m[g] ? byp_d[g*LANE_BITS +: LANE_BITS]
                                                        : raw_rd[g*LANE_BITS +: LANE_BITS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en_r <= 1'b0;
      q_reg  <= '0;
    end else begin
      q_en_r <= rd_a;
      if (rd_a) q_reg <= merged;
    end
  end

  assign q_drv = q_en_r && !oe_n;
  assign q_o   = q_drv ? q_reg : '0;

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> !q_en_r);
  // R2
  a_r2_read_drives: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && gw_n && (bwe_n || (&bw_n))) |=> ##1 q_en_r);
  // R7
  a_r7_two_edge_off: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> ##1 !q_en_r);
  // R8
  a_r8_oe_blocks: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!q_drv && (q_o == '0)));
  // R3
  a_r3_gw_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !gw_n) |=> (wr_a && (&wm_a)));
  // R4
  a_r4_strobes_gated: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && gw_n && bwe_n) |=> (!wr_a && rd_a));
  // R9
  a_r9_desel_no_write: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !wr_a);
endmodule

// File: tb/sim_bw_sync_sram.sv
`timescale 1ns/100ps
module sim_bw_sync_sram;
  localparam int LANES = 4;
  localparam int AW    = 8;
  localparam int W     = LANES * 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ce_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [LANES-1:0] bw_n = '1;
  logic [AW-1:0]    addr_i = '0;
  logic [W-1:0]     d_i = '0;
  logic [W-1:0]     q_o;
  logic             q_drv;

  bw_sync_sram #(.LANES(LANES), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .addr_i(addr_i), .d_i(d_i), .oe_n(oe_n), .q_o(q_o), .q_drv(q_drv)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         due;
    bit         drv;
    logic [W-1:0] data;
    string      req;
  } item_t;

  item_t        sb[$];
  logic [W-1:0] model [256];
  int           cnt = 0;
  int           checks = 0;
  int           fails = 0;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the expected item due in this cycle
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0 && sb[0].due == cnt) begin
      item_t it;
      it = sb.pop_front();
      chk(q_drv == it.drv, {it.req, " drive"}, W'(q_drv), W'(it.drv));
      chk(q_o == it.data, {it.req, " data"}, q_o, it.data);
    end
  end

  // driver: applies one cycle and pushes the expected output
  task automatic cyc(input bit c, input bit g, input bit be, input logic [LANES-1:0] s,
                     input logic [AW-1:0] a, input logic [W-1:0] d, input string req);
    bit wr, rd;
    logic [LANES-1:0] m;
    item_t it;
    @(negedge clk);
    ce_n = c; gw_n = g; bwe_n = be; bw_n = s; addr_i = a; d_i = d;
    m  = !g ? '1 : (be ? '0 : ~s);
    wr = !c && (m != '0);
    rd = !c && !wr;
    if (wr)
      for (int l = 0; l < LANES; l++)
        if (m[l]) model[a][l*9 +: 9] = d[l*9 +: 9];
    it.due  = cnt + 2;
    it.drv  = rd;
    it.data = rd ? model[a] : '0;
    it.req  = req;
    sb.push_back(it);
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return {4'(i * 7 + 3), 32'(i * 32'h9E3779B1 + 32'h1234)};
  endfunction

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(q_drv == 1'b0, "R1 reset drive", W'(q_drv), '0);
    chk(q_o == '0, "R1 reset data", q_o, '0);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(q_drv == 1'b0 && q_o == '0, "R1 after release", q_o, '0);

    // R3 global write ignores strobes, R6 read right after it
    cyc(0, 0, 1, 4'b1111, 8'd5, 36'h1_2345_6789, "R3 gw write");
    cyc(0, 1, 1, 4'b1111, 8'd5, '0, "R3 R6 read after gw");
    // R2 full strobed write, idle, then plain read
    cyc(0, 1, 0, 4'b0000, 8'd9, 36'hA_BCDE_F012, "R5 full strobes");
    cyc(1, 1, 1, 4'b1111, 8'd0, '0, "R7 idle");
    cyc(0, 1, 1, 4'b1111, 8'd9, '0, "R2 read");
    // R5 partial lanes 1 and 3, immediate read merges (R6)
    cyc(0, 1, 0, 4'b0101, 8'd9, 36'h5_5555_5555, "R5 partial write");
    cyc(0, 1, 1, 4'b1111, 8'd9, '0, "R6 merge read");
    // R4 strobes low but byte-write disabled: read
    cyc(0, 1, 1, 4'b0000, 8'd9, 36'hF_FFFF_FFFF, "R4 gated strobes read");
    // R10 byte-write enabled with no strobe: read
    cyc(0, 1, 0, 4'b1111, 8'd9, 36'hF_FFFF_FFFF, "R10 no-strobe read");
    // R9 deselected global write writes nothing
    cyc(1, 0, 0, 4'b0000, 8'd9, 36'h0_0000_0000, "R9 R7 deselect");
    cyc(0, 1, 1, 4'b1111, 8'd9, '0, "R9 read unchanged");
    // R3 gw overrides partial strobes
    cyc(0, 0, 0, 4'b1110, 8'd9, 36'h3_C3C3_C3C3, "R3 gw over strobes");
    cyc(0, 1, 1, 4'b1111, 8'd9, '0, "R3 read all lanes");
    // R7 read then deselect: drive drops two edges later
    cyc(0, 1, 1, 4'b1111, 8'd5, '0, "R2 read");
    cyc(1, 1, 1, 4'b1111, 8'd5, '0, "R7 deselect after read");
    cyc(1, 1, 1, 4'b1111, 8'd5, '0, "R7 second idle");

    // fill and exercise various lane patterns
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 4'b1111, 8'(16 + i), pat(i), "R3 fill");
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 0, 4'(i), 8'(16 + i), ~pat(i + 40), "R5 lane pattern");
      cyc(0, 1, 1, 4'b1111, 8'(16 + i), '0, "R6 pattern read");
      cyc(0, 1, 1, 4'b1111, 8'(16 + ((i + 5) % 16)), '0, "R2 other read");
    end
    // back-to-back writes to two addresses, then reads
    cyc(0, 1, 0, 4'b0011, 8'd40, pat(99), "R5 wr a");
    cyc(0, 0, 1, 4'b1111, 8'd41, pat(98), "R3 wr b");
    cyc(0, 1, 1, 4'b1111, 8'd41, '0, "R6 read b");
    cyc(0, 1, 1, 4'b1111, 8'd16, '0, "R2 read c");

    // R8 asynchronous output enable
    cyc(0, 1, 1, 4'b1111, 8'd41, '0, "R2 read for oe");
    cyc(1, 1, 1, 4'b1111, 8'd0, '0, "R7 idle");
    @(posedge clk); #1.5;
    oe_n = 1'b1; #0.2;
    chk(q_drv == 1'b0 && q_o == '0, "R8 oe high blocks", q_o, '0);
    oe_n = 1'b0; #0.2;
    chk(q_drv == 1'b1 && q_o == pat(98), "R8 oe low restores", q_o, pat(98));

    repeat (6) cyc(1, 1, 1, 4'b1111, 8'd0, '0, "R7 drain");
    repeat (4) @(posedge clk);
    #1.5;
    chk(sb.size() == 0, "R2 scoreboard drained", W'(sb.size()), '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule